// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits at the cycle level of a single-port synchronous SRAM. It has flow-through reads and writes masked per byte lane, and it contains a small behavioural storage array. On every rising clock edge it samples:

- a chip enable and two chip selects;
- two active-low address strobes, one for a processor and one for a cache controller;
- a burst-advance input;
- the write controls;
- the write data.

From these it classifies the cycle as one of four kinds: deselect, begin a new access, continue the burst, or hold the burst address.

A two-bit burst counter produces the word address inside an aligned group of four words. A static order input selects the step pattern:

- interleaved order, where the counter is XORed into the low address bits;
- linear order, where the counter is added to the low address bits modulo four.

Read data comes combinationally from the array, using the address registered at the last edge. There is no output register.

Instead of tristate pins, the block drives a read-valid flag. Two inputs act without waiting for a clock edge: an output-enable, and a sleep input that freezes the state. Read data is a stream with no back-pressure. When `rvalid` is high, `rdata` and `rpar` hold the word at the current burst address. When `rvalid` is low, both buses are driven to zero. A consumer can neither stall nor refuse a word; it must take each word in the cycle it is shown.

Top module: `sync_burst_sram_ctrl`

## Requirements
- R1: A cycle with the chip selected (`en_n`=0, `sel_hi`=1, `sel_lo_n`=0) and either strobe low loads `addr` into the burst counter. If that cycle is a read, `rvalid` goes high right after that edge, and `rdata`/`rpar` show the stored word of `addr` in the same cycle.
- R2: A cycle with either strobe in effect but the chip not selected is a deselect. This covers `ctrl_strobe_n`=0 with `en_n`=1. After a deselect, `rvalid` is low, and later continue or hold cycles stay deselected with no write until the next selected access.
- R3: `proc_strobe_n` has no effect while `en_n`=1. Such a cycle is treated as a continue or hold cycle, and `addr` is not loaded.
- R4: A cycle begun by `proc_strobe_n` is always a read, and all write controls in that cycle are ignored. The write controls are sampled at the following edge.
- R5: A cycle begun by `ctrl_strobe_n` takes the write controls in that same cycle and writes at the loaded address.
- R6: With both strobes high, `adv_n`=0 steps the burst counter by one, and `adv_n`=1 holds the current address. Either kind of cycle may read or write.
- R7: Let b be the loaded low two address bits and k the burst count, which starts at 0 and wraps after four steps. With `linear_order`=0 the word address low bits are b XOR k. With `linear_order`=1 they are (b+k) mod 4. The upper address bits never change during a burst.
- R8: `gwr_n`=0 writes every lane, whatever the values of `bwen_n` and `lane_wr_n`.
- R9: Behaviour when `gwr_n`=1:
  - With `bwen_n`=0, each lane n with `lane_wr_n[n]`=0 is written, and any combination of lanes is allowed.
  - With `bwen_n`=1, the cycle is a read.
  - Lane n covers data bits 8n..8n+7 and parity bit n.
- R10: `rvalid` is high only when both of these hold:
  - the last edge produced a selected access that wrote no lane;
  - `oe_n`=0 and `sleep`=0.

  `oe_n` acts without waiting for a clock edge.
- R11: While `sleep`=1:
  - no edge changes the address or writes the array;
  - `rvalid` is low;
  - stored words are kept.

  After `sleep` falls, the block is deselected until a new selected access.
- R12: After reset, `rvalid` is low and the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| linear_order | input | 1 | Static burst order: 1 linear, 0 interleaved |
| addr | input | AW | External word address |
| wdata | input | 8*LANES | Write data bytes |
| wpar | input | LANES | Write parity bits, one per lane |
| oe_n | input | 1 | Output enable, active low, acts without a clock edge |
| sleep | input | 1 | Sleep: freezes state, blanks output |
| rdata | output | 8*LANES | Read data bytes, zero when not valid |
| rpar | output | LANES | Read parity bits, zero when not valid |
| rvalid | output | 1 | Read word valid |

## Verification
A wrong burst count or a wrong order decode shows as a wrong word on `rdata` in the very cycle after the advancing edge. This is because the read path has no register between the counter and the port. A stale activity or write flag shows up one edge later: either `rvalid` is high after a deselect, sleep or write, or it is missing after a read. Wrong lane masks or a write that should have been ignored stay hidden until the affected address is read back, so every write scenario ends with a read of the touched words.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    K_DESEL = 2'd0,
    K_BEGIN = 2'd1,
    K_STEP  = 2'd2,
    K_HOLD  = 2'd3
  } cyc_kind_t;
endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;

  function automatic logic [1:0] order(input logic [1:0] b, input logic [1:0] c,
                                       input logic lin);
    return lin ? (b + c) : (b ^ c);
  endfunction

  always_comb begin
    base_d = load ? addr_in : base_q;
    cnt_d  = load ? 2'd0 : (step ? cnt_q + 2'd1 : cnt_q);
  end

  assign nxt_addr = {base_d[AW-1:2], order(base_d[1:0], cnt_d, linear)};
  assign cur_addr = {base_q[AW-1:2], order(base_q[1:0], cnt_q, linear)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (!hold) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: a hold cycle keeps the word address
  p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !load && !step) |=> $stable(cur_addr));

  // R7: stepping stays inside the aligned group of four
  p_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !load && step) |=> $stable(cur_addr[AW-1:2]));
endmodule

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             en_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwen_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             active,
  output cyc_kind_t        kind,
  output logic [LANES-1:0] lane_we
);
  logic selected, proc_start, any_start;
  logic [LANES-1:0] ctl_mask;

  assign selected   = !en_n && sel_hi && !sel_lo_n;
  assign proc_start = !proc_strobe_n && !en_n;
  assign any_start  = proc_start || !ctrl_strobe_n;

  always_comb begin
    if (!gwr_n)       ctl_mask = '1;
    else if (!bwen_n) ctl_mask = ~lane_wr_n;
    else              ctl_mask = '0;
  end

  always_comb begin
    kind    = K_HOLD;
    lane_we = '0;
    if (any_start) begin
      kind = selected ? K_BEGIN : K_DESEL;
      if (selected && !proc_start) lane_we = ctl_mask;
    end else begin
      kind = adv_n ? K_HOLD : K_STEP;
      if (active) lane_we = ctl_mask;
    end
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [WW-1:0]    wword,
  input  logic [AW-1:0]    raddr,
  output logic [WW-1:0]    rword
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int g = 0; g < LANES; g++) begin
      if (we[g]) mem[waddr][g*LANE_W +: LANE_W] <= wword[g*LANE_W +: LANE_W];
    end
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/sync_burst_sram_ctrl.sv
module sync_burst_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = 8 * LANES,
  localparam int WW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwen_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             linear_order,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wpar,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [DW-1:0]    rdata,
  output logic [LANES-1:0] rpar,
  output logic             rvalid
);
  cyc_kind_t        kind;
  logic [LANES-1:0] lane_we, arr_we;
  logic             active_q, wr_q;
  logic [AW-1:0]    cur_addr, nxt_addr;
  logic [WW-1:0]    wword, rword;

  sram_cycle_decode #(.LANES(LANES)) u_dec (
    .en_n(en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .adv_n(adv_n), .gwr_n(gwr_n), .bwen_n(bwen_n), .lane_wr_n(lane_wr_n),
    .active(active_q), .kind(kind), .lane_we(lane_we)
  );

  sram_burst_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .hold(sleep),
    .load(kind == K_BEGIN), .step(kind == K_STEP), .linear(linear_order),
    .addr_in(addr), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  assign arr_we = sleep ? '0 : lane_we;

  sram_lane_array #(.LANES(LANES), .DEPTH(DEPTH)) u_arr (
    .clk(clk), .we(arr_we), .waddr(nxt_addr), .wword(wword),
    .raddr(cur_addr), .rword(rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (sleep) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      if (kind == K_BEGIN)      active_q <= 1'b1;
      else if (kind == K_DESEL) active_q <= 1'b0;
      wr_q <= |lane_we;
    end
  end

  assign rvalid = active_q && !wr_q && !oe_n && !sleep;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wword[g*LANE_W +: LANE_W] = {wpar[g], wdata[g*8 +: 8]};
    assign rdata[g*8 +: 8] = rvalid ? rword[g*LANE_W +: 8] : 8'h00;
    assign rpar[g]         = rvalid ? rword[g*LANE_W + 8] : 1'b0;
  end

  // R2: a deselect leaves the read path blank
  p_desel_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ctrl_strobe_n && !(!en_n && sel_hi && !sel_lo_n)) |=> !rvalid);

  // R4: a processor-started cycle never writes
  p_proc_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !proc_strobe_n && !en_n) |-> (arr_we == '0));

  // R8: global write in an active burst writes every lane
  p_gw_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && active_q && !gwr_n && proc_strobe_n && ctrl_strobe_n) |-> (&arr_we));

  // R11: the block wakes deselected
  p_wake_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !rvalid);

  // R11: no writes while asleep
  p_sleep_nowr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (arr_we == '0));
endmodule

// File: tb/sync_burst_sram_ctrl_bench.sv
module sync_burst_sram_ctrl_bench;
  localparam int LANES = 4;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1, sel_hi = 0, sel_lo_n = 1, proc_strobe_n = 1, ctrl_strobe_n = 1;
  logic adv_n = 1, gwr_n = 1, bwen_n = 1, linear_order = 0, oe_n = 0, sleep = 0;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [LANES-1:0] wpar = '0;
  logic [DW-1:0]    rdata;
  logic [LANES-1:0] rpar;
  logic             rvalid;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0]    mdata [DEPTH];
  logic [LANES-1:0] mpar  [DEPTH];

  always #10 clk = ~clk;

  sync_burst_sram_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_sync_burst_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwen_n(bwen_n), .lane_wr_n(lane_wr_n),
    .linear_order(linear_order), .addr(addr), .wdata(wdata), .wpar(wpar),
    .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rpar(rpar), .rvalid(rvalid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle_in();
    en_n = 1; sel_hi = 0; sel_lo_n = 1; proc_strobe_n = 1; ctrl_strobe_n = 1;
    adv_n = 1; gwr_n = 1; bwen_n = 1; lane_wr_n = '1;
  endtask

  task automatic sel_on();
    en_n = 0; sel_hi = 1; sel_lo_n = 0;
  endtask

  task automatic ctrl_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [LANES-1:0] p, input logic gw,
                            input logic bwe, input logic [LANES-1:0] lanes);
    logic [LANES-1:0] m;
    idle_in(); sel_on();
    ctrl_strobe_n = 0; addr = a; wdata = d; wpar = p;
    gwr_n = gw; bwen_n = bwe; lane_wr_n = lanes;
    m = !gw ? '1 : (!bwe ? ~lanes : '0);
    for (int g = 0; g < LANES; g++) begin
      if (m[g]) begin
        mdata[a][g*8 +: 8] = d[g*8 +: 8];
        mpar[a][g] = p[g];
      end
    end
    tick();
    idle_in();
  endtask

  task automatic proc_read(input logic [AW-1:0] a);
    idle_in(); sel_on();
    proc_strobe_n = 0; addr = a;
    tick();
    idle_in();
  endtask

  task automatic expect_word(input string req, input logic [AW-1:0] a);
    check({req, " rvalid"}, 64'(rvalid), 64'(1));
    check({req, " word"}, 64'({rpar, rdata}), 64'({mpar[a], mdata[a]}));
  endtask

  task automatic expect_blank(input string req);
    check({req, " rvalid low"}, 64'(rvalid), 64'(0));
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h11223344 ^ (32'(a) * 32'h01030507);
  endfunction

  task automatic t_reset();
    expect_blank("R12 reset");
  endtask

  task automatic t_fill();
    for (int a = 0; a < 16; a++) ctrl_write(AW'(a), pat(a), LANES'(a), 0, 1, '1);
    expect_blank("R10 write cycle blanks output");
    for (int a = 0; a < 16; a += 5) begin
      proc_read(AW'(a));
      expect_word("R1 R5 single access", AW'(a));
    end
  endtask

  task automatic t_burst_il();
    int seq [4] = '{7, 4, 5, 6};
    linear_order = 0;
    proc_read(6);
    expect_word("R7 interleaved first", 6);
    for (int i = 0; i < 4; i++) begin
      adv_n = 0;
      tick();
      expect_word("R7 interleaved step", AW'(seq[i]));
    end
    adv_n = 1;
  endtask

  task automatic t_burst_lin();
    int seq [4] = '{6, 7, 4, 5};
    linear_order = 1;
    proc_read(5);
    expect_word("R7 linear first", 5);
    for (int i = 0; i < 4; i++) begin
      adv_n = 0;
      tick();
      expect_word("R7 linear step", AW'(seq[i]));
    end
    adv_n = 1;
    linear_order = 0;
  endtask

  task automatic t_suspend();
    proc_read(8);
    adv_n = 0; tick();
    expect_word("R6 advance", 9);
    adv_n = 1; tick();
    expect_word("R6 suspend", 9);
    tick();
    expect_word("R6 suspend again", 9);
  endtask

  task automatic t_proc_read_only();
    idle_in(); sel_on();
    proc_strobe_n = 0; addr = 12; gwr_n = 0; wdata = 32'hDEADBEEF; wpar = 4'hF;
    tick();
    expect_word("R4 processor start reads", 12);
    idle_in();
    gwr_n = 0; wdata = 32'hCAFEF00D; wpar = 4'h5;
    mdata[12] = 32'hCAFEF00D; mpar[12] = 4'h5;
    tick();
    expect_blank("R4 R10 next-edge write");
    gwr_n = 1;
    tick();
    expect_word("R4 next-edge write stored", 12);
  endtask

  task automatic t_bytes();
    ctrl_write(3, 32'hA1B2C3D4, 4'b0101, 1, 0, 4'b1010);
    proc_read(3);
    expect_word("R9 lanes 0 and 2 merged", 3);
    ctrl_write(3, 32'h0, 4'h0, 1, 1, 4'b0000);
    expect_word("R9 byte-write enable high reads", 3);
  endtask

  task automatic t_gw_override();
    ctrl_write(2, 32'h5A5AA5A5, 4'b1001, 0, 0, 4'b1111);
    proc_read(2);
    expect_word("R8 global write all lanes", 2);
  endtask

  task automatic t_deselect();
    proc_read(10);
    idle_in();
    en_n = 0; sel_hi = 0; sel_lo_n = 0; ctrl_strobe_n = 0; addr = 20;
    tick();
    expect_blank("R2 deselect chip select");
    idle_in();
    adv_n = 0; gwr_n = 0; wdata = 32'hFFFFFFFF; wpar = '1;
    tick();
    expect_blank("R2 continue stays deselected");
    idle_in();
    ctrl_strobe_n = 0; en_n = 1;
    tick();
    expect_blank("R2 deselect enable high");
    idle_in();
    proc_read(10);
    expect_word("R2 no write while deselected", 10);
    adv_n = 0; tick();
    expect_word("R2 no write while deselected next", 11);
    adv_n = 1;
  endtask

  task automatic t_ce_gate();
    proc_read(4);
    idle_in();
    proc_strobe_n = 0; en_n = 1; addr = 9;
    tick();
    expect_word("R3 strobe gated, address kept", 4);
    adv_n = 0;
    tick();
    expect_word("R3 strobe gated, burst steps", 5);
    idle_in();
  endtask

  task automatic t_oe();
    proc_read(1);
    oe_n = 1; #1;
    expect_blank("R10 output enable high");
    oe_n = 0; #1;
    expect_word("R10 output enable low again", 1);
  endtask

  task automatic t_sleep();
    proc_read(7);
    sleep = 1; #1;
    expect_blank("R11 sleep blanks");
    idle_in(); sel_on();
    ctrl_strobe_n = 0; addr = 7; gwr_n = 0; wdata = 32'h0BADF00D; wpar = 4'hA;
    tick();
    expect_blank("R11 sleep edge");
    idle_in();
    sleep = 0; #1;
    expect_blank("R11 wake deselected");
    tick();
    expect_blank("R11 wake still deselected");
    proc_read(7);
    expect_word("R11 data retained", 7);
  endtask

  initial begin
    #4000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #5;
    t_reset();
    rst_n = 1;
    tick();
    expect_blank("R12 idle after reset");
    t_fill();
    t_burst_il();
    t_burst_lin();
    t_suspend();
    t_proc_read_only();
    t_bytes();
    t_gw_override();
    t_deselect();
    t_ce_gate();
    t_oe();
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule